// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Parallel Reader

This block runs an external eight-channel, 16-bit converter that samples all of its inputs at one instant and returns its results over a 16-bit parallel bus. After power-up it holds the converter's reset pin high for a set number of cycles. It then starts conversions at a fixed period by raising one shared start strobe. It waits for the converter's busy flag to go high and then low again, and reads the channel results one after another with active-low chip-select and read strobes.

Once all words are in, the block presents them together on a wide output with a one-cycle valid pulse. The words stay there until the next good set arrives. The 3-bit oversampling code is taken from a request input only between conversions, so it cannot change while the converter latches it on the falling edge of busy.

A busy flag that never completes its cycle makes the block abort and restart from the reset pulse. A first-word indicator that does not line up with the first read discards the set.

Top module: `simsamp_reader`

## Requirements
- R1: While `rst` is high, `adc_rst` is 1, `adc_conv` is 0, `adc_cs_n` and `adc_rd_n` are 1, `adc_os` is 0 and `smp_valid` is 0. After `rst` is released, `adc_rst` stays high for exactly RST_CYC cycles.
- R2: The first start strobe begins in the cycle after `adc_rst` falls. Each strobe is high for CONV_HI cycles, and its rising edges are spaced exactly PERIOD cycles apart in normal operation. Chip-select and read are never asserted while the strobe is high.
- R3: Reading starts only after busy has been seen high and then low, and no read is asserted while busy is high. Each set has exactly CH_N read strobes. Each strobe is low for RD_LO cycles, and RD_HI cycles separate consecutive strobes. Chip-select stays low across the whole read phase.
- R4: `adc_os` takes the value of `os_req` only while the block waits between conversions. It is held from the start strobe until the set is finished. A request that changes in the very cycle busy falls is not seen until the next conversion.
- R5: The word on `adc_db` in the last low cycle of the k-th read strobe (k counted from 0, channel 1 first) appears unchanged in `smp_words[k*DW +: DW]`. Two's-complement codes, negative ones included, pass through bit for bit.
- R6: `smp_valid` is a one-cycle pulse that comes in the same cycle as the new words. `smp_words` does not change in any cycle without `smp_valid`.
- R7: If busy has not completed its high-then-low cycle within BUSY_TMO cycles after the start strobe ends, `tmo_pulse` is high for one cycle, `adc_rst` is high in that same cycle, no valid pulse is produced for that set, and the sequence restarts with the reset pulse.
- R8: A set is accepted only if `adc_first` was high on the first read and low on every other read. Otherwise `align_err` pulses for one cycle in place of `smp_valid` and `smp_words` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_req | input | 3 | Requested oversampling code |
| adc_busy | input | 1 | Converter busy flag |
| adc_first | input | 1 | Converter first-word indicator |
| adc_db | input | DW | Converter parallel data bus |
| adc_rst | output | 1 | Converter reset pin |
| adc_conv | output | 1 | Shared conversion start strobe |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_os | output | 3 | Oversampling code to the converter |
| smp_valid | output | 1 | One-cycle pulse marking a new set |
| smp_words | output | CH_N*DW | All channel words, channel 1 in the low DW bits |
| tmo_pulse | output | 1 | Busy timeout pulse |
| align_err | output | 1 | First-word mismatch pulse |

## Verification
Two events can land in the same cycle: the sampling window of the oversampling request and the falling edge of busy. The bench changes `os_req` at the half cycle right after its converter model drops busy. The block therefore sees the new request in the same clock edge where it sees busy low. The check is that `adc_os` keeps its earlier code through the readout and the valid pulse, and shows the new code only after the next start strobe.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

    localparam int OS_W = 3;

    typedef enum logic [2:0] {
        ST_RST,
        ST_IDLE,
        ST_CONV,
        ST_WAITB,
        ST_RDLO,
        ST_RDHI,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic rst;
        logic conv;
        logic cs_n;
        logic rd_n;
    } pin_ctl_t;

    function automatic int cnt_bits(input int n);
        return ($clog2(n + 1) < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/simsamp_seq.sv
module simsamp_seq
    import simsamp_pkg::*;
#(
    parameter int CH_N     = 8,
    parameter int RST_CYC  = 8,
    parameter int CONV_HI  = 2,
    parameter int RD_LO    = 3,
    parameter int RD_HI    = 2,
    parameter int BUSY_TMO = 200,
    parameter int PERIOD   = 400,
    localparam int CW = cnt_bits(CH_N - 1),
    localparam int TW = cnt_bits(max_of(max_of(RST_CYC, CONV_HI),
                                         max_of(max_of(RD_LO, RD_HI), BUSY_TMO))),
    localparam int PW = cnt_bits(PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic [OS_W-1:0] os_req,
    output pin_ctl_t        pins,
    output logic [OS_W-1:0] os_out,
    output logic            cap_en,
    output logic [CW-1:0]   cap_idx,
    output logic            commit,
    output logic            tmo
);
    localparam logic [PW-1:0] PMAX = PW'(PERIOD - 1);

    seq_state_e      st;
    logic [TW-1:0]   tcnt;
    logic [PW-1:0]   per;
    logic [CW-1:0]   ch;
    logic            saw;
    logic [OS_W-1:0] os_q;
    logic            tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_RST;
            tcnt  <= '0;
            per   <= PMAX;
            ch    <= '0;
            saw   <= 1'b0;
            os_q  <= '0;
            tmo_q <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (per != PMAX) per <= per + 1'b1;
            case (st)
                ST_RST: begin
                    per <= PMAX;
                    if (tcnt == TW'(RST_CYC - 1)) begin
                        st   <= ST_IDLE;
                        tcnt <= '0;
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_IDLE: begin
                    os_q <= os_req;
                    if (per == PMAX) begin
                        st   <= ST_CONV;
                        per  <= '0;
                        tcnt <= '0;
                    end
                end
                ST_CONV: begin
                    if (tcnt == TW'(CONV_HI - 1)) begin
                        st   <= ST_WAITB;
                        tcnt <= '0;
                        saw  <= 1'b0;
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_WAITB: begin
                    if (busy) saw <= 1'b1;
                    // a completed busy cycle wins over an expiring timer
                    if (saw && !busy) begin
                        st   <= ST_RDLO;
                        tcnt <= '0;
                        ch   <= '0;
                    end else if (tcnt == TW'(BUSY_TMO - 1)) begin
                        st    <= ST_RST;
                        tcnt  <= '0;
                        tmo_q <= 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_RDLO: begin
                    if (tcnt == TW'(RD_LO - 1)) begin
                        tcnt <= '0;
                        st   <= (ch == CW'(CH_N - 1)) ? ST_DONE : ST_RDHI;
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_RDHI: begin
                    if (tcnt == TW'(RD_HI - 1)) begin
                        tcnt <= '0;
                        ch   <= ch + 1'b1;
                        st   <= ST_RDLO;
                    end else tcnt <= tcnt + 1'b1;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_RST;
            endcase
        end
    end

    always_comb begin
        pins.rst  = (st == ST_RST);
        pins.conv = (st == ST_CONV);
        pins.cs_n = !((st == ST_RDLO) || (st == ST_RDHI));
        pins.rd_n = (st != ST_RDLO);
    end

    assign cap_en  = (st == ST_RDLO) && (tcnt == TW'(RD_LO - 1));
    assign cap_idx = ch;
    assign commit  = (st == ST_DONE);
    assign os_out  = os_q;
    assign tmo     = tmo_q;

    // R4: the oversampling code moves only in the inter-conversion wait
    p_os_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(os_q))
        else $error("R4 oversampling code moved outside the wait state");

    // R3: reading never begins before busy was observed high
    p_read_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAITB && $past(st) == ST_WAITB && !saw) |=> (st != ST_RDLO))
        else $error("R3 read began without a busy cycle");

endmodule

// File: rtl/simsamp_bank.sv
module simsamp_bank #(
    parameter int CH_N = 8,
    parameter int DW   = 16,
    parameter int CW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [CW-1:0]      cap_idx,
    input  logic [DW-1:0]      db,
    input  logic               first,
    input  logic               commit,
    output logic [CH_N*DW-1:0] words,
    output logic               valid,
    output logic               aerr
);
    logic [DW-1:0]      sh [CH_N];
    logic [CH_N-1:0]    fs;
    logic [CH_N*DW-1:0] sh_flat;
    logic               aligned;

    generate
        for (genvar g = 0; g < CH_N; g++) begin : g_flat
            assign sh_flat[g*DW +: DW] = sh[g];
        end
    endgenerate

    assign aligned = fs[0] && (fs[CH_N-1:1] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CH_N; i++) sh[i] <= '0;
            fs    <= '0;
            words <= '0;
            valid <= 1'b0;
            aerr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            aerr  <= 1'b0;
            if (cap_en) begin
                sh[cap_idx] <= db;
                fs[cap_idx] <= first;
            end
            if (commit) begin
                if (aligned) begin
                    words <= sh_flat;
                    valid <= 1'b1;
                end else aerr <= 1'b1;
            end
        end
    end

    // R8: a commit yields exactly one of the two outcomes
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        commit |=> (valid != aerr))
        else $error("R8 commit outcome not exclusive");

endmodule

// File: rtl/simsamp_reader.sv
module simsamp_reader
    import simsamp_pkg::*;
#(
    parameter int CH_N     = 8,
    parameter int DW       = 16,
    parameter int RST_CYC  = 8,
    parameter int CONV_HI  = 2,
    parameter int RD_LO    = 3,
    parameter int RD_HI    = 2,
    parameter int BUSY_TMO = 200,
    parameter int PERIOD   = 400
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         os_req,
    input  logic               adc_busy,
    input  logic               adc_first,
    input  logic [DW-1:0]      adc_db,
    output logic               adc_rst,
    output logic               adc_conv,
    output logic               adc_cs_n,
    output logic               adc_rd_n,
    output logic [2:0]         adc_os,
    output logic               smp_valid,
    output logic [CH_N*DW-1:0] smp_words,
    output logic               tmo_pulse,
    output logic               align_err
);
    localparam int CW = cnt_bits(CH_N - 1);

    pin_ctl_t      pins;
    logic          cap_en;
    logic [CW-1:0] cap_idx;
    logic          commit;

    simsamp_seq #(
        .CH_N(CH_N), .RST_CYC(RST_CYC), .CONV_HI(CONV_HI), .RD_LO(RD_LO),
        .RD_HI(RD_HI), .BUSY_TMO(BUSY_TMO), .PERIOD(PERIOD)
    ) seq_i (
        .clk(clk), .rst(rst), .busy(adc_busy), .os_req(os_req),
        .pins(pins), .os_out(adc_os), .cap_en(cap_en), .cap_idx(cap_idx),
        .commit(commit), .tmo(tmo_pulse)
    );

    simsamp_bank #(.CH_N(CH_N), .DW(DW), .CW(CW)) bank_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
        .db(adc_db), .first(adc_first), .commit(commit),
        .words(smp_words), .valid(smp_valid), .aerr(align_err)
    );

    assign adc_rst  = pins.rst;
    assign adc_conv = pins.conv;
    assign adc_cs_n = pins.cs_n;
    assign adc_rd_n = pins.rd_n;

    p_no_read_busy_r3: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> !adc_busy)
        else $error("R3 bus access while busy");

    p_conv_bus_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        adc_conv |-> (adc_cs_n && adc_rd_n))
        else $error("R2 bus access during start strobe");

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid)
        else $error("R6 valid longer than one cycle");

    p_words_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> $stable(smp_words))
        else $error("R6 words changed without valid");

    p_tmo_restart_r7: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |-> (adc_rst && !smp_valid))
        else $error("R7 timeout without restart");

endmodule

// File: tb/simsamp_reader_tb_top.sv
module simsamp_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CH_N = 8, DW = 16, RST_CYC = 6, CONV_HI = 2;
    localparam int RD_LO = 3, RD_HI = 2, BUSY_TMO = 60, PERIOD = 150;
    localparam int CONV_T = 15;

    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] os_req = 3'd0;
    logic adc_busy, adc_first;
    logic [DW-1:0] adc_db;
    logic adc_rst, adc_conv, adc_cs_n, adc_rd_n, smp_valid, tmo_pulse, align_err;
    logic [2:0] adc_os;
    logic [CH_N*DW-1:0] smp_words;

    int n_cmp = 0, n_fail = 0, cyc = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simsamp_reader #(
        .CH_N(CH_N), .DW(DW), .RST_CYC(RST_CYC), .CONV_HI(CONV_HI), .RD_LO(RD_LO),
        .RD_HI(RD_HI), .BUSY_TMO(BUSY_TMO), .PERIOD(PERIOD)
    ) dut_i (
        .clk(clk), .rst(rst), .os_req(os_req), .adc_busy(adc_busy),
        .adc_first(adc_first), .adc_db(adc_db), .adc_rst(adc_rst),
        .adc_conv(adc_conv), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_os(adc_os), .smp_valid(smp_valid), .smp_words(smp_words),
        .tmo_pulse(tmo_pulse), .align_err(align_err)
    );

    // behavioural converter
    logic [DW-1:0] ch_data [CH_N];
    logic suppress = 1'b0;
    int first_pos = 0;
    logic conv_d, rd_d;
    int bcnt;
    logic [3:0] idx;

    always @(posedge clk) begin
        if (rst) begin
            adc_busy <= 1'b0; conv_d <= 1'b0; rd_d <= 1'b1; idx <= '0; bcnt <= 0;
        end else begin
            conv_d <= adc_conv;
            rd_d   <= adc_rd_n;
            if (adc_conv && !conv_d && !suppress) begin
                adc_busy <= 1'b1; bcnt <= CONV_T; idx <= '0;
            end else begin
                if (adc_busy) begin
                    if (bcnt <= 1) adc_busy <= 1'b0;
                    bcnt <= bcnt - 1;
                end
                if (adc_rd_n && !rd_d) idx <= idx + 1'b1;
            end
        end
    end

    assign adc_db    = (!adc_cs_n && int'(idx) < CH_N) ? ch_data[idx[2:0]] : '0;
    assign adc_first = !adc_cs_n && (int'(idx) == first_pos);

    // bus monitor sampled at falling edges
    logic cpm = 1'b0, rpm = 1'b1;
    int lo_run = 0, rises = 0, badw = 0, gap = 0, last_gap = 0;
    always @(negedge clk) begin
        gap++;
        if (adc_conv && !cpm) begin last_gap = gap; gap = 0; rises = 0; badw = 0; end
        if (!adc_rd_n) lo_run++;
        else if (!rpm) begin
            rises++;
            if (lo_run != RD_LO) badw++;
            lo_run = 0;
        end
        cpm = adc_conv;
        rpm = adc_rd_n;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_cmp++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [CH_N*DW-1:0] act,
                       input logic [CH_N*DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CH_N*DW-1:0] exp_words();
        logic [CH_N*DW-1:0] w;
        for (int k = 0; k < CH_N; k++) w[k*DW +: DW] = ch_data[k];
        return w;
    endfunction

    task automatic wait_valid(input int limit, output bit ok);
        ok = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (smp_valid) begin ok = 1; return; end
        end
    endtask

    task automatic wait_conv();
        logic prev = adc_conv;
        for (int i = 0; i < 4*PERIOD; i++) begin
            @(negedge clk);
            if (adc_conv && !prev) return;
            prev = adc_conv;
        end
    endtask

    task automatic set_pattern(input int sel);
        for (int k = 0; k < CH_N; k++)
            ch_data[k] = (sel == 0) ? DW'(16'h1000 + k * 16'h0111)
                       : (sel == 1) ? DW'(16'h8000 + k * 3)
                                    : DW'(16'hFFFF - k * 16'h0101);
    endtask

    task automatic t_reset();
        int n;
        set_pattern(0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 adc_rst in reset", adc_rst, 1);
        chk("R1 conv in reset", adc_conv, 0);
        chk("R1 cs_n/rd_n in reset", {adc_cs_n, adc_rd_n}, 2'b11);
        chk("R1 os in reset", adc_os, 0);
        chk("R1 valid in reset", smp_valid, 0);
        rst = 1'b0;
        n = 0;
        while (adc_rst && n < 100) begin n++; @(negedge clk); end
        chk("R1 reset pulse length", n, RST_CYC);
        @(negedge clk);
        chk("R2 first strobe after reset", adc_conv, 1);
    endtask

    task automatic t_frame(input int sel);
        bit ok;
        set_pattern(sel);
        wait_conv();
        wait_valid(2*PERIOD, ok);
        chk("R6 valid arrives", ok, 1);
        chk("R5 words in channel order", smp_words, exp_words());
        chk("R3 read strobe count", rises, CH_N);
        chk("R3 read strobe low width", badw, 0);
        @(negedge clk);
        chk("R6 valid single cycle", smp_valid, 0);
        repeat (5) @(negedge clk);
        chk("R6 words held", smp_words, exp_words());
    endtask

    task automatic t_period();
        wait_conv();
        wait_conv();
        chk("R2 start period", last_gap, PERIOD);
    endtask

    task automatic t_os();
        bit ok;
        os_req = 3'b101;
        wait_conv();
        chk("R4 code at start", adc_os, 3'b101);
        while (!adc_busy) @(negedge clk);
        while (adc_busy) @(negedge clk);
        os_req = 3'b010;   // seen by the block together with busy low
        wait_valid(2*PERIOD, ok);
        chk("R4 code held through readout", adc_os, 3'b101);
        wait_conv();
        chk("R4 new code on next conversion", adc_os, 3'b010);
    endtask

    task automatic t_timeout();
        bit ok, seen = 0;
        int nv = 0;
        wait_valid(2*PERIOD, ok);
        suppress = 1'b1;
        for (int i = 0; i < 2*PERIOD + BUSY_TMO; i++) begin
            @(negedge clk);
            if (smp_valid) nv++;
            if (tmo_pulse) begin
                seen = 1;
                chk("R7 reset with timeout", adc_rst, 1);
                break;
            end
        end
        chk("R7 timeout raised", seen, 1);
        chk("R7 no valid on timeout", nv, 0);
        suppress = 1'b0;
        set_pattern(2);
        wait_valid(3*PERIOD, ok);
        chk("R7 recovery set", smp_words, exp_words());
    endtask

    task automatic t_align();
        bit ok, seen = 0;
        int nv = 0;
        logic [CH_N*DW-1:0] saved;
        wait_valid(2*PERIOD, ok);
        saved = smp_words;
        first_pos = 3;
        set_pattern(1);
        for (int i = 0; i < 2*PERIOD; i++) begin
            @(negedge clk);
            if (smp_valid) nv++;
            if (align_err) begin seen = 1; break; end
        end
        chk("R8 align error raised", seen, 1);
        chk("R8 no valid on misalignment", nv, 0);
        chk("R8 words kept", smp_words, saved);
        first_pos = 0;
        wait_valid(2*PERIOD, ok);
        chk("R8 good set after realign", smp_words, exp_words());
    endtask

    initial begin
        t_reset();
        t_frame(0);
        t_frame(1);
        t_frame(2);
        t_period();
        t_os();
        t_timeout();
        t_align();
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule